// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This execution unit treats each 32-bit operand as a bundle of small signed integers. It holds either two 16-bit lanes, with the upper lane in bits 31:16 and the lower lane in bits 15:0, or four 8-bit lanes. It adds or subtracts every lane on its own, and no carry crosses a lane boundary. Each add or subtract can wrap or clamp. The unit also narrows a 32-bit signed intermediate to a 16-bit sample by an arithmetic right shift followed by a clamp. A pack operation joins one chosen half of each source into a single word, so results return to paired form for storage.

A request is accepted on any cycle in which `inValid` is high. The result appears one clock later, together with `outValid`. A sticky flag records that some lane was clamped. The flag stays set until the caller pulses `satClr`. Multiplication, memory access and instruction decode stay outside this unit.

Top module: `packed_simd_alu`

## Requirements
- R1: While `rstN` is low, `outValid`, `result` and `satFlag` are all 0.
- R2: When `inValid` is high at a rising edge, `outValid` is high in the following cycle and `result` carries that request's answer. In a cycle after an edge with `inValid` low, `outValid` is low and `result` keeps its previous value.
- R3: Opcode 0 adds and opcode 1 subtracts (A minus B). With `laneSel`=0, both work modulo 2^16 in each of the two 16-bit lanes, and no carry or borrow passes between the lanes.
- R4: With `laneSel`=1, opcodes 0 and 1 work modulo 2^8 in each of the four 8-bit lanes (bits 7:0, 15:8, 23:16, 31:24), and each lane is independent of the others.
- R5: Opcode 2 adds and opcode 3 subtracts with saturation. With `laneSel`=0, a 16-bit lane that overflows upward becomes 0x7FFF, and one that overflows downward becomes 0x8000.
- R6: With `laneSel`=1, opcodes 2 and 3 clamp each 8-bit lane to 0x7F on upward overflow and to 0x80 on downward overflow.
- R7: Opcode 4 shifts `srcA`, taken as signed 32-bit, arithmetically right by `shamt` (0 to 31). It clamps the value to the range -32768 to 32767 and returns it sign-extended to 32 bits. `srcB`, `laneSel` and `halfSel` have no effect on this result.
- R8: Opcode 5 packs. `result[31:16]` is the upper half of `srcA` when `halfSel[1]`=1, else the lower half. `result[15:0]` is the upper half of `srcB` when `halfSel[0]`=1, else the lower half.
- R9: `satFlag` goes high one cycle after an accepted request in which any lane or the narrowed value was clamped. It stays high until `satClr` is sampled high. A clamp accepted in the same cycle as `satClr` leaves the flag high. Opcodes 0, 1 and 5 never set it.
- R10: Opcodes 6 and 7 produce a result of 0 and never set `satFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Request valid |
| opcode | input | 3 | Operation select (0 to 7) |
| laneSel | input | 1 | 0: two 16-bit lanes, 1: four 8-bit lanes |
| halfSel | input | 2 | Pack half choice: bit 1 for srcA, bit 0 for srcB |
| srcA | input | 32 | First operand |
| srcB | input | 32 | Second operand |
| shamt | input | 5 | Right shift amount for narrowing |
| satClr | input | 1 | Clears the sticky saturation flag |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 32 | Registered result |
| satFlag | output | 1 | Sticky saturation indicator |

## Verification
The bench builds the unit with its default lane width of 16 bits. From that width come the 8-bit byte lanes, the 32-bit word and the 5-bit shift amount, so both lane layouts are reached in one build. At this size the bench can drive every exact clamp boundary directly: 0x7FFF plus one, 0x8000 minus one, and the 8-bit equivalents. It can also drive shift amounts of 0 and 31, and every pack half combination.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_QADD = 3'd2,
    OP_QSUB = 3'd3,
    OP_NSAT = 3'd4,
    OP_PACK = 3'd5
  } simdOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ld;        // accept a request this cycle
    logic clr;       // clear sticky flag
    logic selArith;  // lane add/sub path
    logic doSub;     // subtract instead of add
    logic saturate;  // clamp instead of wrap
    logic byteLanes; // four narrow lanes instead of two
    logic selShift;  // narrowing shift path
    logic selPack;   // pack path
  } simdStrb_t;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] opcode,
  input  logic       laneSel,
  input  logic       satClr,
  output simdStrb_t  strb
);

  always_comb begin
    strb           = '0;
    strb.ld        = inValid;
    strb.clr       = satClr;
    strb.byteLanes = laneSel;
    unique case (opcode)
      OP_ADD:  strb.selArith = 1'b1;
      OP_SUB:  begin strb.selArith = 1'b1; strb.doSub = 1'b1; end
      OP_QADD: begin strb.selArith = 1'b1; strb.saturate = 1'b1; end
      OP_QSUB: begin strb.selArith = 1'b1; strb.doSub = 1'b1; strb.saturate = 1'b1; end
      OP_NSAT: strb.selShift = 1'b1;
      OP_PACK: strb.selPack = 1'b1;
      default: ;
    endcase
  end

  // R10: at most one result path chosen
  path_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selArith, strb.selShift, strb.selPack}));

endmodule

// File: rtl/simd_dp.sv
module simd_dp
  import simd_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  simdStrb_t                    strb,
  input  logic [1:0]                   halfSel,
  input  logic [2*HALF_W-1:0]          srcA,
  input  logic [2*HALF_W-1:0]          srcB,
  input  logic [$clog2(2*HALF_W)-1:0]  shamt,
  output logic                         outValid,
  output logic [2*HALF_W-1:0]          result,
  output logic                         satFlag
);

  localparam int WORD_W = 2 * HALF_W;
  localparam int BYTE_W = HALF_W / 2;
  localparam int NHALF  = WORD_W / HALF_W;
  localparam int NBYTE  = WORD_W / BYTE_W;

  logic [WORD_W-1:0] halfWrap, halfSat, byteWrap, byteSat;
  logic [NHALF-1:0]  halfOvf;
  logic [NBYTE-1:0]  byteOvf;

  // Wide lanes
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W:0] opA, opB, sum;
    assign opA = {srcA[h*HALF_W+HALF_W-1], srcA[h*HALF_W +: HALF_W]};
    assign opB = {srcB[h*HALF_W+HALF_W-1], srcB[h*HALF_W +: HALF_W]};
    assign sum = strb.doSub ? (opA - opB) : (opA + opB);
    assign halfOvf[h] = sum[HALF_W] ^ sum[HALF_W-1];
    assign halfWrap[h*HALF_W +: HALF_W] = sum[HALF_W-1:0];
    assign halfSat[h*HALF_W +: HALF_W] = !halfOvf[h] ? sum[HALF_W-1:0] :
      (sum[HALF_W] ? {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, {(HALF_W-1){1'b1}}});
  end

  // Narrow lanes
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic [BYTE_W:0] opA, opB, sum;
    assign opA = {srcA[b*BYTE_W+BYTE_W-1], srcA[b*BYTE_W +: BYTE_W]};
    assign opB = {srcB[b*BYTE_W+BYTE_W-1], srcB[b*BYTE_W +: BYTE_W]};
    assign sum = strb.doSub ? (opA - opB) : (opA + opB);
    assign byteOvf[b] = sum[BYTE_W] ^ sum[BYTE_W-1];
    assign byteWrap[b*BYTE_W +: BYTE_W] = sum[BYTE_W-1:0];
    assign byteSat[b*BYTE_W +: BYTE_W] = !byteOvf[b] ? sum[BYTE_W-1:0] :
      (sum[BYTE_W] ? {1'b1, {(BYTE_W-1){1'b0}}} : {1'b0, {(BYTE_W-1){1'b1}}});
  end

  // Narrowing shift with clamp
  logic signed [WORD_W-1:0] shifted;
  logic [WORD_W-HALF_W:0]   upperBits;
  logic                     shOvf;
  logic [HALF_W-1:0]        shClamp;
  logic [WORD_W-1:0]        shRes;

  assign shifted   = $signed(srcA) >>> shamt;
  assign upperBits = shifted[WORD_W-1:HALF_W-1];
  assign shOvf     = !((&upperBits) || !(|upperBits));
  assign shClamp   = !shOvf ? shifted[HALF_W-1:0] :
    (shifted[WORD_W-1] ? {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, {(HALF_W-1){1'b1}}});
  assign shRes     = {{HALF_W{shClamp[HALF_W-1]}}, shClamp};

  // Pack
  logic [WORD_W-1:0] packRes;
  assign packRes = {halfSel[1] ? srcA[WORD_W-1:HALF_W] : srcA[HALF_W-1:0],
                    halfSel[0] ? srcB[WORD_W-1:HALF_W] : srcB[HALF_W-1:0]};

  // Result select
  logic [WORD_W-1:0] nextRes;
  logic              satNow;

  always_comb begin
    nextRes = '0;
    satNow  = 1'b0;
    if (strb.selArith) begin
      if (strb.byteLanes) begin
        nextRes = strb.saturate ? byteSat : byteWrap;
        satNow  = strb.saturate && (|byteOvf);
      end else begin
        nextRes = strb.saturate ? halfSat : halfWrap;
        satNow  = strb.saturate && (|halfOvf);
      end
    end else if (strb.selShift) begin
      nextRes = shRes;
      satNow  = shOvf;
    end else if (strb.selPack) begin
      nextRes = packRes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      satFlag  <= 1'b0;
    end else begin
      outValid <= strb.ld;
      if (strb.ld) result <= nextRes;
      satFlag  <= (strb.clr ? 1'b0 : satFlag) | (strb.ld & satNow);
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ld |=> outValid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ld |=> (!outValid && $stable(result)));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !strb.clr) |=> satFlag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clr && !strb.ld) |=> !satFlag);

  // R9
  wrap_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!satFlag && !strb.saturate && !strb.selShift) |=> !satFlag);

endmodule

// File: rtl/packed_simd_alu.sv
module packed_simd_alu
  import simd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  opcode,
  input  logic        laneSel,
  input  logic [1:0]  halfSel,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  input  logic [4:0]  shamt,
  input  logic        satClr,
  output logic        outValid,
  output logic [31:0] result,
  output logic        satFlag
);

  simdStrb_t strb;

  simd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opcode  (opcode),
    .laneSel (laneSel),
    .satClr  (satClr),
    .strb    (strb)
  );

  simd_dp #(.HALF_W(16)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .halfSel  (halfSel),
    .srcA     (srcA),
    .srcB     (srcB),
    .shamt    (shamt),
    .outValid (outValid),
    .result   (result),
    .satFlag  (satFlag)
  );

endmodule

// File: tb/test_packed_simd_alu.sv
`timescale 1ns/1ps
module test_packed_simd_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opcode = '0;
  logic        laneSel = 1'b0;
  logic [1:0]  halfSel = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [4:0]  shamt = '0;
  logic        satClr = 1'b0;
  logic        outValid;
  logic [31:0] result;
  logic        satFlag;

  int total = 0;
  int bad = 0;
  bit modelFlag = 1'b0;
  logic [32:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  packed_simd_alu i_packed_simd_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .laneSel(laneSel), .halfSel(halfSel), .srcA(srcA), .srcB(srcB),
    .shamt(shamt), .satClr(satClr), .outValid(outValid),
    .result(result), .satFlag(satFlag)
  );

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model built from the requirement text: bit 32 is "clamped"
  function automatic logic [32:0] modelOp(input int op, input bit lane8, input logic [1:0] hs,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [4:0] sh);
    logic [31:0] r = '0;
    bit s = 1'b0;
    int lw = lane8 ? 8 : 16;
    int n = 32 / lw;
    int hi = (1 << (lw - 1)) - 1;
    int lo = -(1 << (lw - 1));
    int mask = (1 << lw) - 1;
    if (op <= 3) begin
      for (int k = 0; k < n; k++) begin
        int x = int'((a >> (k * lw)) & 32'(mask));
        int y = int'((b >> (k * lw)) & 32'(mask));
        int z;
        if (x > hi) x -= (1 << lw);
        if (y > hi) y -= (1 << lw);
        z = (op == 1 || op == 3) ? x - y : x + y;
        if (op >= 2) begin
          if (z > hi) begin z = hi; s = 1'b1; end
          else if (z < lo) begin z = lo; s = 1'b1; end
        end
        r |= (32'(z) & 32'(mask)) << (k * lw);
      end
    end else if (op == 4) begin
      int v = $signed(a) >>> sh;
      if (v > 32767) begin v = 32767; s = 1'b1; end
      else if (v < -32768) begin v = -32768; s = 1'b1; end
      r = 32'(v);
    end else if (op == 5) begin
      r = {hs[1] ? a[31:16] : a[15:0], hs[0] ? b[31:16] : b[15:0]};
    end
    return {s, r};
  endfunction

  task automatic send(input int op, input bit l8, input logic [1:0] hs,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [4:0] sh, input bit clr, input string req);
    logic [32:0] m;
    @(negedge clk);
    inValid = 1'b1; opcode = 3'(op); laneSel = l8; halfSel = hs;
    srcA = a; srcB = b; shamt = sh; satClr = clr;
    m = modelOp(op, l8, hs, a, b, sh);
    modelFlag = (clr ? 1'b0 : modelFlag) | m[32];
    expQ.push_back({modelFlag, m[31:0]});
    tagQ.push_back(req);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      inValid = 1'b0; satClr = 1'b0;
    end
  endtask

  task automatic clearOnly();
    @(negedge clk);
    inValid = 1'b0; satClr = 1'b1;
    modelFlag = 1'b0;
    @(negedge clk);
    satClr = 1'b0;
    check("R9 clear", {32'd0, satFlag}, {32'd0, 1'b0});
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected", {satFlag, result}, 33'd0);
        if (!({satFlag, result} !== 33'd0)) ; 
      end else begin
        logic [32:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {satFlag, result}, e);
      end
    end
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", {outValid, satFlag, result[30:0]}, 33'd0);
    check("R1 reset result", {1'b0, result}, 33'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R3: lane wrap without carry between halves
    send(0, 0, 2'b00, 32'h0000FFFF, 32'h00000001, 5'd0, 0, "R3 add16 nocarry");
    send(1, 0, 2'b00, 32'h00000000, 32'h00000001, 5'd0, 0, "R3 sub16 noborrow");
    send(0, 0, 2'b00, 32'h7FFF8000, 32'h0001FFFF, 5'd0, 0, "R3 add16 wrap");
    // R4
    send(0, 1, 2'b00, 32'h01FF7F80, 32'h01017F80, 5'd0, 0, "R4 add8 wrap");
    send(1, 1, 2'b00, 32'h00800010, 32'h01010020, 5'd0, 0, "R4 sub8 wrap");
    idle(2);
    check("R9 wrap no flag", {32'd0, satFlag}, 33'd0);
    // R2 hold
    held = result;
    idle(2);
    check("R2 hold", {outValid, result}, {1'b0, held});

    // R5
    send(2, 0, 2'b00, 32'h7FFF0001, 32'h00010002, 5'd0, 0, "R5 qadd16 pos");
    send(3, 0, 2'b00, 32'h80000005, 32'h00010003, 5'd0, 0, "R5 qsub16 neg");
    send(2, 0, 2'b00, 32'h80007FFF, 32'h80007FFF, 5'd0, 0, "R5 qadd16 both");
    idle(2);
    clearOnly();
    // R6
    send(2, 1, 2'b00, 32'h7F80107F, 32'h01FF1000, 5'd0, 0, "R6 qadd8");
    send(3, 1, 2'b00, 32'h807F0000, 32'h01FF8001, 5'd0, 0, "R6 qsub8");
    idle(2);
    clearOnly();
    send(2, 1, 2'b00, 32'h10203040, 32'h01020304, 5'd0, 0, "R6 qadd8 in range");
    idle(2);
    check("R9 no clamp no flag", {32'd0, satFlag}, 33'd0);

    // R7
    send(4, 1, 2'b11, 32'h00001234, 32'hFFFFFFFF, 5'd0, 0, "R7 shift0");
    send(4, 0, 2'b00, 32'h7FFFFFFF, 32'h0, 5'd31, 0, "R7 shift31 pos");
    send(4, 0, 2'b00, 32'h80000000, 32'h0, 5'd31, 0, "R7 shift31 neg");
    send(4, 0, 2'b00, 32'h00123456, 32'h0, 5'd4, 0, "R7 clamp pos");
    send(4, 0, 2'b00, 32'hFF000000, 32'h0, 5'd8, 1, "R9 clamp with clear");
    send(4, 0, 2'b00, 32'hFFFF0000, 32'h0, 5'd1, 0, "R7 neg fits");
    idle(2);
    check("R9 flag survives clear", {32'd0, satFlag}, {32'd0, 1'b1});
    clearOnly();

    // R8
    for (int h = 0; h < 4; h++)
      send(5, 0, 2'(h), 32'hAAAA5555, 32'h1234CDEF, 5'd0, 0, "R8 pack");
    // R10
    send(6, 0, 2'b00, 32'h7FFF7FFF, 32'h7FFF7FFF, 5'd3, 0, "R10 op6");
    send(7, 1, 2'b11, 32'h80808080, 32'h7F7F7F7F, 5'd0, 0, "R10 op7");
    idle(3);
    check("R10 no flag", {32'd0, satFlag}, 33'd0);
    check("R2 queue drained", 33'(expQ.size()), 33'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule